// File: doc/BRIEF.md
# Timestamped Hit Queue Readout Controller

This block collects hit events from a bank of 64 channels and prepares them for transfer to external memory. A channel counts as hit only when its leading-edge discriminator and its energy filter both report it in the same clock. All such channels in one clock form a single queue record. The record holds the free-running 48-bit timestamp of that clock, a 64-bit mask with one bit per fired channel, and three caller-supplied flag bits. Records wait in a 1024-deep first-in first-out store.

A readout walker takes the oldest record. It presents the record's timestamp and flags, and raises a transfer request for each channel marked in the mask, one at a time, lowest index first. The addressed channel's own data queue moves its item toward the memory-write port and acknowledges with a done pulse. When the store nears capacity, a pause line tells the timing system to hold off. The pause line uses hysteresis so that it does not toggle on every record.

Top module: `hq_readout_ctrl`

## Requirements
- R1: `ts_out` is 0 during reset and in the clock after `sync_clr` is high. In every other clock it increments by 1.
- R2: Channel i is a hit only when `disc_hit[i]` and `filt_ok[i]` are both 1 in the same clock. Either one alone stores nothing.
- R3: All channels hit in one clock form one record. The record holds the `ts_out` value of that clock, a mask with bit i set for hit channel i, and the `hit_flags` of that clock.
- R4: The store holds at most 1024 records that have not yet been taken. A hit arriving while it is full is dropped, and the stored records are kept.
- R5: Records are taken oldest first. When the walker is idle and the store is non-empty at a clock edge, it takes the oldest record at that edge. From then on, `cur_ts` and `cur_flags` show that record's timestamp and flags.
- R6: While a record is open, `xfer_req` is 1 and `xfer_ch` names the lowest channel of the mask that is not yet serviced. Both hold steady until `xfer_done` is 1 at a clock edge, which retires that channel. Channels are therefore serviced in ascending index order.
- R7: After the last channel of a record retires, `xfer_req` is 0 for at least one clock before the next record opens.
- R8: `pause` rises in the clock after the number of stored records is at least 1000. It falls in the clock after that number is at most 900. Otherwise it keeps its value.
- R9: During reset, `xfer_req` and `pause` are 0, `ts_out` is 0, and the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_clr | input | 1 | Clears the timestamp counter |
| disc_hit | input | 64 | Per-channel leading-edge discriminator fire |
| filt_ok | input | 64 | Per-channel energy filter confirmation |
| hit_flags | input | 3 | Flag bits stored with the record |
| xfer_done | input | 1 | Channel data queue finished the requested transfer |
| xfer_req | output | 1 | Transfer request to a channel data queue |
| xfer_ch | output | 6 | Channel index addressed by the request |
| cur_ts | output | 48 | Timestamp of the open record |
| cur_flags | output | 3 | Flags of the open record |
| ts_out | output | 48 | Live timestamp counter |
| pause | output | 1 | Backpressure indication to the timing system |

## Verification
Storing a new record and taking the oldest one can happen at the same clock edge. A channel retirement can also coincide with new hits arriving. A pause threshold can be crossed in the same clock as a pop.

The bench provokes these overlaps with sparse random hits while `xfer_done` is randomly withheld. It then fills the store past capacity with the walker stalled, and drains it with `xfer_done` held high. A behavioural queue model predicts every output on every clock. The number of completed handshakes over the drain confirms that exactly the storable records survive the overflow.

// File: rtl/hqr_pkg.sv
package hqr_pkg;
    localparam int NCH    = 64;
    localparam int TS_W   = 48;
    localparam int FLAG_W = 3;
    localparam int CH_W   = $clog2(NCH);

    typedef struct packed {
        logic [TS_W-1:0]   ts;
        logic [NCH-1:0]    mask;
        logic [FLAG_W-1:0] flags;
    } hq_entry_t;

    typedef enum logic {W_IDLE, W_BUSY} walk_state_t;

    function automatic logic [CH_W-1:0] lowest_idx(input logic [NCH-1:0] m);
        logic [CH_W-1:0] idx;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i]) idx = CH_W'(i);
        end
        return idx;
    endfunction
endpackage

// File: rtl/hq_tstamp.sv
module hq_tstamp
    import hqr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            sync_clr,
    output logic [TS_W-1:0] ts
);
    always_ff @(posedge clk) begin
        if (rst || sync_clr) ts <= '0;
        else                 ts <= ts + 1'b1;
    end
endmodule

// File: rtl/hq_store.sv
module hq_store
    import hqr_pkg::*;
#(
    parameter int DEPTH    = 1024,
    parameter int PAUSE_HI = 1000,
    parameter int PAUSE_LO = 900,
    localparam int AW      = $clog2(DEPTH),
    localparam int FW      = AW + 1
)(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_req,
    input  hq_entry_t wr_data,
    input  logic      rd_en,
    output hq_entry_t rd_data,
    output logic      empty,
    output logic [FW-1:0] fill,
    output logic      pause
);
    hq_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, wr_en, rd_ok;

    assign empty = (fill == '0);
    assign full  = (fill == FW'(DEPTH));
    assign wr_en = wr_req && !full;
    assign rd_ok = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            fill <= fill + FW'(wr_en) - FW'(rd_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                       pause <= 1'b0;
        else if (fill >= FW'(PAUSE_HI)) pause <= 1'b1;
        else if (fill <= FW'(PAUSE_LO)) pause <= 1'b0;
    end
endmodule

// File: rtl/hq_walker.sv
module hq_walker
    import hqr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              empty,
    input  hq_entry_t         head,
    output logic              pop,
    input  logic              xfer_done,
    output logic              xfer_req,
    output logic [CH_W-1:0]   xfer_ch,
    output logic [TS_W-1:0]   cur_ts,
    output logic [FLAG_W-1:0] cur_flags
);
    walk_state_t      state;
    logic [NCH-1:0]   remain;
    logic [NCH-1:0]   retire_bit;

    assign pop        = (state == W_IDLE) && !empty;
    assign xfer_req   = (state == W_BUSY);
    assign xfer_ch    = lowest_idx(remain);
    assign retire_bit = NCH'(1) << xfer_ch;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= W_IDLE;
            remain    <= '0;
            cur_ts    <= '0;
            cur_flags <= '0;
        end else begin
            case (state)
                W_IDLE: if (pop) begin
                    state     <= W_BUSY;
                    remain    <= head.mask;
                    cur_ts    <= head.ts;
                    cur_flags <= head.flags;
                end
                W_BUSY: if (xfer_done) begin
                    remain <= remain & ~retire_bit;
                    if ((remain & ~retire_bit) == '0) state <= W_IDLE;
                end
                default: state <= W_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hq_readout_ctrl.sv
module hq_readout_ctrl
    import hqr_pkg::*;
#(
    parameter int DEPTH    = 1024,
    parameter int PAUSE_HI = 1000,
    parameter int PAUSE_LO = 900,
    localparam int FW      = $clog2(DEPTH) + 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_clr,
    input  logic [NCH-1:0]    disc_hit,
    input  logic [NCH-1:0]    filt_ok,
    input  logic [FLAG_W-1:0] hit_flags,
    input  logic              xfer_done,
    output logic              xfer_req,
    output logic [CH_W-1:0]   xfer_ch,
    output logic [TS_W-1:0]   cur_ts,
    output logic [FLAG_W-1:0] cur_flags,
    output logic [TS_W-1:0]   ts_out,
    output logic              pause
);
    logic [NCH-1:0] hit_vec;
    hq_entry_t      new_ent, head;
    logic           pop, empty;
    logic [FW-1:0]  fill_lvl;

    assign hit_vec       = disc_hit & filt_ok;
    assign new_ent.ts    = ts_out;
    assign new_ent.mask  = hit_vec;
    assign new_ent.flags = hit_flags;

    hq_tstamp u_ts (
        .clk(clk), .rst(rst), .sync_clr(sync_clr), .ts(ts_out)
    );

    hq_store #(.DEPTH(DEPTH), .PAUSE_HI(PAUSE_HI), .PAUSE_LO(PAUSE_LO)) u_store (
        .clk(clk), .rst(rst), .wr_req(|hit_vec), .wr_data(new_ent),
        .rd_en(pop), .rd_data(head), .empty(empty), .fill(fill_lvl), .pause(pause)
    );

    hq_walker u_walk (
        .clk(clk), .rst(rst), .empty(empty), .head(head), .pop(pop),
        .xfer_done(xfer_done), .xfer_req(xfer_req), .xfer_ch(xfer_ch),
        .cur_ts(cur_ts), .cur_flags(cur_flags)
    );
endmodule

// File: rtl/hq_readout_ctrl_chk.sv
module hq_readout_ctrl_chk
    import hqr_pkg::*;
#(
    parameter int DEPTH    = 1024,
    parameter int PAUSE_HI = 1000,
    parameter int PAUSE_LO = 900,
    localparam int FW      = $clog2(DEPTH) + 1
)(
    input logic            clk,
    input logic            rst,
    input logic            sync_clr,
    input logic            xfer_done,
    input logic            xfer_req,
    input logic [CH_W-1:0] xfer_ch,
    input logic [TS_W-1:0] ts_out,
    input logic            pause,
    input logic [FW-1:0]   fill
);
    a_r1_ts_sync: assert property (@(posedge clk) disable iff (rst)
        sync_clr |=> ts_out == '0);
    a_r1_ts_step: assert property (@(posedge clk) disable iff (rst)
        !sync_clr |=> ts_out == $past(ts_out) + 1'b1);
    a_r4_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill <= FW'(DEPTH));
    a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
        xfer_req && !xfer_done |=> xfer_req && $stable(xfer_ch));
    a_r6_ascending: assert property (@(posedge clk) disable iff (rst)
        xfer_req && xfer_done |=> !xfer_req || (xfer_ch > $past(xfer_ch)));
    a_r8_pause_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(pause) |-> $past(fill) >= FW'(PAUSE_HI));
    a_r8_pause_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(pause) |-> $past(fill) <= FW'(PAUSE_LO));
    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> !xfer_req && !pause && ts_out == '0 && fill == '0);
endmodule

bind hq_readout_ctrl hq_readout_ctrl_chk #(
    .DEPTH(DEPTH), .PAUSE_HI(PAUSE_HI), .PAUSE_LO(PAUSE_LO)
) u_chk (
    .clk(clk), .rst(rst), .sync_clr(sync_clr), .xfer_done(xfer_done),
    .xfer_req(xfer_req), .xfer_ch(xfer_ch), .ts_out(ts_out),
    .pause(pause), .fill(fill_lvl)
);

// File: tb/hq_readout_ctrl_bench.sv
`timescale 1ns/1ps
module hq_readout_ctrl_bench;
    localparam int DEPTH = 1024;
    localparam int HI    = 1000;
    localparam int LO    = 900;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_clr = 1'b0;
    logic [63:0] disc_hit = '0;
    logic [63:0] filt_ok = '0;
    logic [2:0]  hit_flags = '0;
    logic        xfer_done = 1'b0;
    logic        xfer_req;
    logic [5:0]  xfer_ch;
    logic [47:0] cur_ts;
    logic [2:0]  cur_flags;
    logic [47:0] ts_out;
    logic        pause;

    int checks = 0;
    int fails  = 0;
    int done_mode = 0;
    bit count_en = 0;
    int handshakes = 0;

    always #5 clk = ~clk;

    hq_readout_ctrl u_hq_readout_ctrl (
        .clk(clk), .rst(rst), .sync_clr(sync_clr), .disc_hit(disc_hit),
        .filt_ok(filt_ok), .hit_flags(hit_flags), .xfer_done(xfer_done),
        .xfer_req(xfer_req), .xfer_ch(xfer_ch), .cur_ts(cur_ts),
        .cur_flags(cur_flags), .ts_out(ts_out), .pause(pause)
    );

    // behavioural reference
    logic [114:0] m_q[$];
    logic [47:0]  m_ts = '0;
    bit           m_busy = 0;
    logic [63:0]  m_rem = '0;
    logic [47:0]  m_cts = '0;
    logic [2:0]   m_cfl = '0;
    bit           m_pause = 0;

    function automatic int low(logic [63:0] m);
        for (int i = 0; i < 64; i++) if (m[i]) return i;
        return 0;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int oc;
        logic [63:0] h;
        logic [114:0] e;
        if (rst) begin
            m_q.delete(); m_ts = '0; m_busy = 0; m_rem = '0;
            m_cts = '0; m_cfl = '0; m_pause = 0;
        end else begin
            oc = m_q.size();
            h  = disc_hit & filt_ok;
            if (!m_busy) begin
                if (oc > 0) begin
                    e = m_q.pop_front();
                    m_busy = 1; m_rem = e[66:3]; m_cts = e[114:67]; m_cfl = e[2:0];
                end
            end else if (xfer_done) begin
                m_rem[low(m_rem)] = 1'b0;
                if (m_rem == '0) m_busy = 0;
            end
            if (h != '0 && oc < DEPTH) m_q.push_back({m_ts, h, hit_flags});
            if (oc >= HI) m_pause = 1;
            else if (oc <= LO) m_pause = 0;
            m_ts = sync_clr ? '0 : m_ts + 1'b1;
        end
        if (count_en && xfer_req && xfer_done) handshakes++;
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        check("R1 ts_out", 64'(ts_out), 64'(m_ts));
        check("R7 xfer_req", 64'(xfer_req), 64'(m_busy));
        if (m_busy) check("R6 xfer_ch", 64'(xfer_ch), 64'(low(m_rem)));
        check("R3 cur_ts", 64'(cur_ts), 64'(m_cts));
        check("R5 cur_flags", 64'(cur_flags), 64'(m_cfl));
        check("R8 pause", 64'(pause), 64'(m_pause));
        case (done_mode)
            0: xfer_done <= 1'b1;
            1: xfer_done <= 1'b0;
            default: xfer_done <= ($urandom % 3) == 0;
        endcase
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        cyc(3);
        check("R9 reset req", 64'(xfer_req), 0);
        check("R9 reset pause", 64'(pause), 0);
        check("R9 reset ts", 64'(ts_out), 0);
        rst = 1'b0;
        cyc(6);
        sync_clr = 1'b1; cyc(1); sync_clr = 1'b0; cyc(3);
        // R2: lone discriminator or lone filter stores nothing
        disc_hit = 64'h20; cyc(1); disc_hit = '0;
        filt_ok = 64'h40; cyc(1); filt_ok = '0;
        cyc(4);
        check("R2 no record", 64'(xfer_req), 0);
        // R3/R6: one multi-channel record
        done_mode = 0;
        disc_hit = 64'h8000_0100_0000_0008; filt_ok = '1; hit_flags = 3'd5;
        cyc(1); disc_hit = '0; filt_ok = '0; hit_flags = '0;
        cyc(10);
        // random traffic with irregular acknowledges
        done_mode = 2;
        for (int i = 0; i < 400; i++) begin
            disc_hit  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            filt_ok   = {$urandom, $urandom};
            if ($urandom % 4 != 0) disc_hit = '0;
            hit_flags = 3'($urandom);
            sync_clr  = ($urandom % 50) == 0;
            cyc(1);
        end
        disc_hit = '0; filt_ok = '0; sync_clr = 1'b0;
        done_mode = 0;
        cyc(800);
        check("R7 drained", 64'(xfer_req), 0);
        // R4/R8: overflow with the walker stalled, then drain
        done_mode = 1;
        cyc(2);
        handshakes = 0; count_en = 1;
        for (int i = 0; i < 1100; i++) begin
            disc_hit = 64'(1) << (i % 64); filt_ok = '1;
            cyc(1);
        end
        disc_hit = '0; filt_ok = '0;
        cyc(2);
        check("R8 pause high when full", 64'(pause), 1);
        done_mode = 0;
        cyc(3000);
        check("R4 records kept", 64'(handshakes), 64'(DEPTH + 1));
        check("R8 pause released", 64'(pause), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule